// File: doc/BRIEF.md
# Sorted Memory Hex Printer with Sort/Print Sequencer

This block sits between a sort engine, the memory that engine works on, and a byte-wide serial transmitter. A single request on `run_go` makes the sequencer launch the sort, wait until the sort engine says it has finished, then start the printer. The sequencer then waits for the printer to finish and reports that the whole run is complete.

The printer walks the memory from the lowest address to the highest. It reads each 16-bit word with one cycle of read latency and turns the word into one line of ASCII text: four uppercase hexadecimal digits, then a carriage return and a line feed. It hands that text to the transmitter one byte at a time, using a valid/busy handshake. The bit-level serializer sits outside the block and is seen only through that handshake.

Top module: `sorted_hexdump`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `sort_start`, `dump_start`, `dump_done`, `run_done`, `mem_rd_en` and `tx_valid` are all low.
- R2: A `run_go` sampled while the sequencer is idle produces a `sort_start` pulse of exactly one cycle in the next cycle.
- R3: A `sort_done` sampled while the sequencer waits for the sort produces a `dump_start` pulse of exactly one cycle in the next cycle. `dump_start` never rises without a preceding `sort_done`.
- R4: During a dump, `mem_rd_en` pulses once per word for one cycle. `mem_rd_addr` takes the values 0, 1, …, N-1 in that order, and N defaults to 16.
- R5: Each word yields exactly six transmitted bytes: its four nibbles from most significant to least significant as hex digits, then 0x0D, then 0x0A. A dump therefore sends 6·N bytes.
- R6: A nibble value v from 0 to 9 is sent as 0x30+v. A value from 10 to 15 is sent as 0x41+(v-10), which are the uppercase letters.
- R7: `tx_valid` is raised only in a cycle whose preceding edge saw `tx_busy` low. It lasts exactly one cycle, and that pulse counts as acceptance of `tx_data`.
- R8: The word placed in the line is the value on `mem_rd_data` two clock edges after the edge that launched `mem_rd_en`, which is one cycle of read latency. Values present at any other time are not used.
- R9: `dump_done` pulses for one cycle, in the cycle after the one in which the final line feed of word N-1 was presented with `tx_valid`.
- R10: `run_done` pulses for one cycle in the cycle after `dump_done`. A `run_go` that arrives while a run is in progress is ignored and produces no extra `sort_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_go | input | 1 | Request one sort-then-print run |
| run_done | output | 1 | One-cycle pulse when the run has finished |
| sort_start | output | 1 | One-cycle pulse that launches the sort engine |
| sort_done | input | 1 | Pulse from the sort engine when it has finished |
| dump_start | output | 1 | One-cycle pulse that starts the printer |
| dump_done | output | 1 | One-cycle pulse after the last byte has been accepted |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address, where AW = clog2(N) |
| mem_rd_data | input | W | Read data, valid one cycle after the strobe |
| tx_data | output | 8 | ASCII byte for the transmitter |
| tx_valid | output | 1 | One-cycle byte strobe |
| tx_busy | input | 1 | Transmitter is shifting out a byte |

## Verification
The assertions assume that the transmitter raises `tx_busy` only after it has taken a byte, never in the same cycle as `tx_valid`. They also assume that `sort_done` arrives only after a `sort_start`. The bench transmitter model raises busy at the edge following an accepted byte and holds it for a random one to four cycles. The sort model pulses `sort_done` once, after a random delay that follows each `sort_start`. The memory model drives garbage outside its one-cycle read window, so a printer that latches early or late prints wrong digits.

// File: rtl/dump_pkg.sv
package dump_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SORT = 2'd1,
    SEQ_DUMP = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    PR_IDLE  = 2'd0,
    PR_WAIT  = 2'd1,
    PR_LATCH = 2'd2,
    PR_SEND  = 2'd3
  } pr_state_t;

  localparam logic [7:0] ASCII_CR = 8'h0D;
  localparam logic [7:0] ASCII_LF = 8'h0A;

  // nibble to uppercase hex character
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
    logic [7:0] r;
    if (nib < 4'd10) r = 8'h30 + {4'd0, nib};
    else             r = 8'h41 + {4'd0, nib - 4'd10};
    return r;
  endfunction

endpackage

// File: rtl/hex_line_sel.sv
module hex_line_sel
  import dump_pkg::*;
#(
  parameter int W    = 16,
  localparam int DIG  = W / 4,
  localparam int LINE = DIG + 2,
  localparam int IW   = $clog2(LINE)
) (
  input  logic [W-1:0]  word,
  input  logic [IW-1:0] idx,
  output logic [7:0]    char_out
);

  logic [7:0] chars [LINE];

  for (genvar k = 0; k < DIG; k++) begin : g_digit
    assign chars[k] = nib_to_ascii(word[W-1-4*k -: 4]);
  end
  assign chars[DIG]   = ASCII_CR;
  assign chars[DIG+1] = ASCII_LF;

  always_comb begin
    char_out = ASCII_LF;
    for (int k = 0; k < LINE; k++) begin
      if (idx == IW'(k)) char_out = chars[k];
    end
  end

endmodule

// File: rtl/run_seq.sv
module run_seq
  import dump_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic sort_start,
  input  logic sort_done,
  output logic dump_start,
  input  logic dump_done,
  output logic run_done
);

  seq_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      sort_start <= 1'b0;
      dump_start <= 1'b0;
      run_done   <= 1'b0;
    end else begin
      sort_start <= 1'b0;
      dump_start <= 1'b0;
      run_done   <= 1'b0;
      case (state)
        SEQ_IDLE: if (go) begin
          sort_start <= 1'b1;
          state      <= SEQ_SORT;
        end
        SEQ_SORT: if (sort_done) begin
          dump_start <= 1'b1;
          state      <= SEQ_DUMP;
        end
        SEQ_DUMP: if (dump_done) begin
          run_done <= 1'b1;
          state    <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/word_printer.sv
module word_printer
  import dump_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16,
  localparam int AW   = (N > 1) ? $clog2(N) : 1,
  localparam int LINE = W / 4 + 2,
  localparam int IW   = $clog2(LINE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_data,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_busy
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(N - 1);
  localparam logic [IW-1:0] LAST_IDX  = IW'(LINE - 1);

  pr_state_t     state;
  logic [W-1:0]  word_q;
  logic [IW-1:0] idx;
  logic [7:0]    next_char;

  hex_line_sel #(.W(W)) u_sel (
    .word     (word_q),
    .idx      (idx),
    .char_out (next_char)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PR_IDLE;
      done     <= 1'b0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      word_q   <= '0;
      idx      <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_en    <= 1'b0;
      tx_valid <= 1'b0;
      case (state)
        PR_IDLE: if (start) begin
          rd_addr <= '0;
          rd_en   <= 1'b1;
          state   <= PR_WAIT;
        end
        PR_WAIT:  state <= PR_LATCH;
        PR_LATCH: begin
          word_q <= rd_data;
          idx    <= '0;
          state  <= PR_SEND;
        end
        PR_SEND: begin
          if (tx_valid) begin
            if (idx == LAST_IDX) begin
              if (rd_addr == LAST_ADDR) begin
                done  <= 1'b1;
                state <= PR_IDLE;
              end else begin
                rd_addr <= rd_addr + 1'b1;
                rd_en   <= 1'b1;
                state   <= PR_WAIT;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end else if (!tx_busy) begin
            tx_data  <= next_char;
            tx_valid <= 1'b1;
          end
        end
        default: state <= PR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sorted_hexdump.sv
module sorted_hexdump #(
  parameter int N = 16,
  parameter int W = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_go,
  output logic          run_done,
  output logic          sort_start,
  input  logic          sort_done,
  output logic          dump_start,
  output logic          dump_done,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [W-1:0]  mem_rd_data,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_busy
);

  run_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (run_go),
    .sort_start (sort_start),
    .sort_done  (sort_done),
    .dump_start (dump_start),
    .dump_done  (dump_done),
    .run_done   (run_done)
  );

  word_printer #(.N(N), .W(W)) u_prn (
    .clk      (clk),
    .rst      (rst),
    .start    (dump_start),
    .done     (dump_done),
    .rd_en    (mem_rd_en),
    .rd_addr  (mem_rd_addr),
    .rd_data  (mem_rd_data),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_busy  (tx_busy)
  );

endmodule

// File: rtl/sorted_hexdump_chk.sv
module sorted_hexdump_chk #(
  parameter int N = 16,
  parameter int W = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          run_go,
  input logic          run_done,
  input logic          sort_start,
  input logic          sort_done,
  input logic          dump_start,
  input logic          dump_done,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic [W-1:0]  mem_rd_data,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_busy
);

  p_sort_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    sort_start |=> !sort_start);

  p_dump_after_sort_r3: assert property (@(posedge clk) disable iff (rst)
    dump_start |-> $past(sort_done));

  p_read_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_addr_range_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (int'(mem_rd_addr) < N));

  p_tx_free_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !tx_busy);

  p_tx_single_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  p_no_tx_on_read_r8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !tx_valid);

  p_done_after_byte_r9: assert property (@(posedge clk) disable iff (rst)
    dump_done |-> $past(tx_valid));

  p_run_done_r10: assert property (@(posedge clk) disable iff (rst)
    run_done |-> $past(dump_done));

  p_done_char_r5: assert property (@(posedge clk) disable iff (rst)
    dump_done |-> (tx_data == 8'h0A));

endmodule

bind sorted_hexdump sorted_hexdump_chk #(.N(N), .W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_go      (run_go),
  .run_done    (run_done),
  .sort_start  (sort_start),
  .sort_done   (sort_done),
  .dump_start  (dump_start),
  .dump_done   (dump_done),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_data (mem_rd_data),
  .tx_data     (tx_data),
  .tx_valid    (tx_valid),
  .tx_busy     (tx_busy)
);

// File: tb/tb_sorted_hexdump.sv
module tb_sorted_hexdump;
  localparam int N  = 16;
  localparam int W  = 16;
  localparam int AW = $clog2(N);
  localparam int NB = 6 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_go = 1'b0;
  logic          sort_done = 1'b0;
  logic          tx_busy = 1'b0;
  logic [W-1:0]  mem_rd_data = '0;
  logic          run_done, sort_start, dump_start, dump_done, mem_rd_en, tx_valid;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    tx_data;

  always #2 clk = ~clk;

  sorted_hexdump #(.N(N), .W(W)) dut (
    .clk(clk), .rst(rst), .run_go(run_go), .run_done(run_done),
    .sort_start(sort_start), .sort_done(sort_done),
    .dump_start(dump_start), .dump_done(dump_done),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_busy(tx_busy)
  );

  logic [W-1:0] mem  [N];
  logic [7:0]   rbuf [NB];
  int nchk = 0, nfail = 0;
  int cyc = 0, rec_cnt = 0, addr_cnt = 0, last_rec_cyc = 0;
  bit pend_en = 0, arm = 0, prev_valid = 0;
  logic [AW-1:0] pend_addr = '0;
  int busy_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] v);
    return (v < 10) ? 8'(8'h30 + v) : 8'(8'h41 + (v - 10));
  endfunction

  function automatic logic [7:0] exp_byte(input logic [W-1:0] w, input int k);
    case (k)
      0: return hexc(w[15:12]);
      1: return hexc(w[11:8]);
      2: return hexc(w[7:4]);
      3: return hexc(w[3:0]);
      4: return 8'h0D;
      default: return 8'h0A;
    endcase
  endfunction

  // memory, transmitter and watchdog models, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rd_data = pend_en ? mem[pend_addr] : W'($urandom);   // R8 window
      pend_en   = mem_rd_en;
      pend_addr = mem_rd_addr;
      if (mem_rd_en) begin
        chk(int'(mem_rd_addr) == addr_cnt, "R4 addr order", int'(mem_rd_addr), addr_cnt);
        addr_cnt++;
      end
      if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) tx_busy = 1'b0;
      end
      if (arm) begin
        tx_busy = 1'b1;
        busy_cnt = 1 + int'($urandom % 4);
        arm = 0;
      end
      if (tx_valid) begin
        chk(!prev_valid, "R7 one-cycle valid", 1, 0);
        if (rec_cnt < NB) rbuf[rec_cnt] = tx_data;
        rec_cnt++;
        last_rec_cyc = cyc;
        arm = 1;
      end
      prev_valid = tx_valid;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  task automatic sort_mem(input bit asc);
    for (int i = 0; i < N - 1; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (asc ? (mem[j] > mem[j+1]) : (mem[j] < mem[j+1])) begin
          logic [W-1:0] t = mem[j];
          mem[j] = mem[j+1];
          mem[j+1] = t;
        end
  endtask

  task automatic do_run(input bit asc);
    @(negedge clk); run_go = 1'b1;
    @(negedge clk); run_go = 1'b0;
    chk(sort_start == 1'b1, "R2 sort_start pulse", sort_start, 1);
    @(negedge clk);
    chk(sort_start == 1'b0, "R2 sort_start width", sort_start, 0);
    run_go = 1'b1;
    @(negedge clk); run_go = 1'b0;
    @(negedge clk);
    chk(sort_start == 1'b0, "R10 ignored run_go", sort_start, 0);
    repeat (2 + int'($urandom % 6)) begin
      @(negedge clk);
      chk(!tx_valid && !mem_rd_en && !dump_start, "R3 idle before sort_done", 1, 0);
    end
    sort_mem(asc);
    rec_cnt = 0; addr_cnt = 0;
    sort_done = 1'b1;
    @(negedge clk); sort_done = 1'b0;
    chk(dump_start == 1'b1, "R3 dump_start pulse", dump_start, 1);
    while (!dump_done) @(negedge clk);
    chk(cyc == last_rec_cyc + 1, "R9 done timing", cyc, last_rec_cyc + 1);
    chk(rec_cnt == NB, "R5 byte count", rec_cnt, NB);
    chk(addr_cnt == N, "R4 read count", addr_cnt, N);
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 6; k++)
        chk(rbuf[6*i+k] == exp_byte(mem[i], k), (k < 4) ? "R6 digit" : "R5 line end",
            rbuf[6*i+k], exp_byte(mem[i], k));
    @(negedge clk);
    chk(run_done == 1'b1, "R10 run_done", run_done, 1);
    chk(dump_done == 1'b0, "R9 done width", dump_done, 0);
    @(negedge clk);
    chk(run_done == 1'b0, "R10 run_done width", run_done, 0);
    while (tx_busy) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(!sort_start && !dump_start && !dump_done && !run_done && !mem_rd_en && !tx_valid,
        "R1 outputs in reset", 1, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sort_start && !dump_start && !dump_done && !run_done && !mem_rd_en && !tx_valid,
        "R1 outputs after reset", 1, 0);
    // directed: every digit value, plus extremes
    for (int i = 0; i < N; i++) mem[i] = W'($urandom);
    mem[0] = 16'h0123; mem[1] = 16'h4567; mem[2] = 16'h89AB; mem[3] = 16'hCDEF;
    mem[4] = 16'h0000; mem[5] = 16'hFFFF; mem[6] = 16'h9A9A;
    do_run(1'b1);
    for (int i = 0; i < N; i++) mem[i] = W'($urandom);
    do_run(1'b0);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) mem[i] = W'($urandom);
      do_run(r[0]);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule